// File: doc/BRIEF.md
# Modulo Counter with Split-Byte Register Access

This block is a 16-bit up-counter that software reaches through a narrow 8-bit register port. A programmable 16-bit limit sets the counting period: once the count equals the limit, the next timer tick returns the count to zero and raises an overflow flag. The flag can drive an interrupt line when enabled. A timer-tick enable input paces the count. It is normally driven by a prescaler outside the block.

Each 16-bit quantity is split into a high and a low byte, and the block keeps the two halves consistent across separate bus accesses:

- When software reads the count's high byte, the block freezes a copy of the low byte for the read that follows.
- When software writes the limit's high byte, overflow reporting is held off until the low byte completes the new value. The new limit only takes effect as a whole 16-bit word.

A debug-break input halts counting and leaves any pending low-byte copy in place.

Top module: `split_mod_timer`

## Requirements
- R1: On a tick (tick_en high, dbg_brk low) where the count equals the active limit, the count becomes 0x0000 and the overflow flag (status bit 7) is set; on any other tick the count increments by one.
- R2: After reset, both limit bytes read 0xFF, the count reads 0x0000, the status register reads 0x00 and irq is low.
- R3: A write to the limit high byte (address 3) opens a window in which wraps do not set the overflow flag; a write to the limit low byte (address 4) closes it.
- R4: A read of the count high byte (address 1) captures the count low byte; the next read of the count low byte (address 2) returns the captured value and releases the capture, after which reads return the live low byte.
- R5: A captured low byte stays held while dbg_brk is high and after it falls, until the count low byte is read.
- R6: While dbg_brk is high the count does not advance, and a status read does not arm the flag-clear sequence.
- R7: Writing the status register with bit 5 set forces the count to 0x0000; bit 5 always reads 0.
- R8: On cycles with tick_en low the count holds its value.
- R9: The overflow flag clears only when a status write with bit 7 at 0 follows a status read that saw the flag set; a status write with bit 7 at 1, or a 0 write without that prior read, leaves the flag set.
- R10: irq is high exactly when the overflow flag and the interrupt enable (status bit 6) are both set.
- R11: The compare uses the previous full limit until the low byte is written; the limit high byte reads back the staged byte.
- R12: The count registers (addresses 1 and 2) ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Timer tick qualifier; the count moves only when high |
| dbg_brk | input | 1 | Debug break; halts counting and flag-clear arming |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | 0 status, 1 count high, 2 count low, 3 limit high, 4 limit low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the access cycle |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default 16-bit count and 8-bit bus. At that size the high byte and the low-byte capture are both exercised with counts above 255, for example 0x012C and 0x0131. Small limits such as 3 let a full wrap fit in a handful of ticks. This allows the suppression window, the staged high byte and the flag-clear handshake to be run through several complete wraps. Running the count for hundreds of ticks with the limit at 0xFFFF separates the captured low byte from the live one. Break cycles in the middle of such a run show that counting stopped while the capture was still held.

// File: rtl/smt_pkg.sv
// Package: register addresses and status bit positions shared by the
// split-byte modulo timer. Assumes an 8-bit register port.
package smt_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_L = 3'd2;
    localparam logic [ADDR_W-1:0] A_LIM_H = 3'd3;
    localparam logic [ADDR_W-1:0] A_LIM_L = 3'd4;
    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_CRST = 5;
endpackage

// File: rtl/smt_count_core.sv
// Counter core: counts on qualified ticks, compares against the active
// limit and restarts from zero on the tick after a match. Assumes clr has
// priority over counting and that halt freezes the count entirely.
module smt_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         halt,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic adv;

    // qualified advance and the wrap event seen by the flag logic
    always_comb begin
        adv  = tick && !halt && !clr;
        wrap = adv && (cnt == limit);
    end

    // count register with forced clear and restart on match
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (wrap)   cnt <= '0;
        else if (adv)    cnt <= cnt + 1'b1;
    end

    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !clr && cnt == limit) |=> (cnt == '0));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
    a_r6_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> $stable(cnt));
endmodule

// File: rtl/smt_limit_stage.sv
// Limit register: the high byte is staged and the full word commits on the
// low-byte write. Overflow suppression spans staged-high to low write.
// Assumes W = 2*BW.
module smt_limit_stage #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [BW-1:0] wdata,
    output logic [W-1:0]  limit,
    output logic [BW-1:0] staged_hi,
    output logic          suppress
);
    localparam int HW = W - BW;

    // staging byte for the upper half
    always_ff @(posedge clk) begin
        if (!rst_n)     staged_hi <= '1;
        else if (wr_hi) staged_hi <= wdata[HW-1:0];
    end

    // whole-word commit on low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)     limit <= '1;
        else if (wr_lo) limit <= {staged_hi, wdata};
    end

    // suppression window open from high write until low write
    always_ff @(posedge clk) begin
        if (!rst_n)     suppress <= 1'b0;
        else if (wr_lo) suppress <= 1'b0;
        else if (wr_hi) suppress <= 1'b1;
    end

    a_r11_word_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(limit));
    a_r3_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> suppress);
endmodule

// File: rtl/smt_read_latch.sv
// Low-byte capture: a high-byte read freezes the low byte; the next low-byte
// read returns it and releases. Break has no effect on release.
module smt_read_latch #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_hi,
    input  logic          rd_lo,
    input  logic [BW-1:0] live_lo,
    output logic [BW-1:0] lo_view
);
    logic          held;
    logic [BW-1:0] snap;

    // capture on high read, release on low read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            snap <= '0;
        end else if (rd_hi) begin
            held <= 1'b1;
            snap <= live_lo;
        end else if (rd_lo) begin
            held <= 1'b0;
        end
    end

    // low-byte view seen by the read mux
    always_comb lo_view = held ? snap : live_lo;

    a_r4_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rd_hi) |=> $stable(snap));
    a_r5_held_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rd_lo) |=> held);
endmodule

// File: rtl/smt_flag_ctl.sv
// Overflow flag with read-then-write-zero clear handshake and interrupt
// enable. Assumes a status read and write never share a cycle.
module smt_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic suppress,
    input  logic brk,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wflag,
    input  logic wie,
    output logic flag,
    output logic ie,
    output logic irq
);
    logic armed;

    // arm on a status read that sees the flag, outside break
    always_ff @(posedge clk) begin
        if (!rst_n)                       armed <= 1'b0;
        else if (wr_stat)                 armed <= 1'b0;
        else if (rd_stat && flag && !brk) armed <= 1'b1;
    end

    // flag: set on unsuppressed wrap, clear on armed zero write
    always_ff @(posedge clk) begin
        if (!rst_n)                            flag <= 1'b0;
        else if (wrap && !suppress)            flag <= 1'b1;
        else if (wr_stat && armed && !wflag)   flag <= 1'b0;
    end

    // interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (wr_stat) ie <= wie;
    end

    // request line
    always_comb irq = flag && ie;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (suppress && !flag) |=> !flag);
    a_r9_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);
    a_r6_no_arm_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !armed) |=> !armed);
endmodule

// File: rtl/split_mod_timer.sv
// Top: 8-bit register port over a 16-bit modulo counter. Decodes accesses,
// routes side effects and muxes read data combinationally in the access
// cycle. Assumes one access per bus_sel cycle.
module split_mod_timer
    import smt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbg_brk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int HI_W = CNT_W - BUS_W;

    logic rd, wr;
    logic rd_stat, wr_stat, rd_ch, rd_cl, wr_lh, wr_ll, cnt_clr;
    logic [CNT_W-1:0] cnt, limit;
    logic [HI_W-1:0]  staged_hi;
    logic [BUS_W-1:0] lo_view;
    logic wrap, suppress, flag, ie;

    // access decode
    always_comb begin
        rd      = bus_sel && !bus_wr;
        wr      = bus_sel &&  bus_wr;
        rd_stat = rd && (bus_addr == A_STAT);
        wr_stat = wr && (bus_addr == A_STAT);
        rd_ch   = rd && (bus_addr == A_CNT_H);
        rd_cl   = rd && (bus_addr == A_CNT_L);
        wr_lh   = wr && (bus_addr == A_LIM_H);
        wr_ll   = wr && (bus_addr == A_LIM_L);
        cnt_clr = wr_stat && bus_wdata[B_CRST];
    end

    smt_count_core #(.W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .halt(dbg_brk),
        .clr(cnt_clr), .limit(limit), .cnt(cnt), .wrap(wrap)
    );

    smt_limit_stage #(.W(CNT_W), .BW(BUS_W)) lim_i (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_lh), .wr_lo(wr_ll),
        .wdata(bus_wdata), .limit(limit), .staged_hi(staged_hi),
        .suppress(suppress)
    );

    smt_read_latch #(.BW(BUS_W)) lat_i (
        .clk(clk), .rst_n(rst_n), .rd_hi(rd_ch), .rd_lo(rd_cl),
        .live_lo(cnt[BUS_W-1:0]), .lo_view(lo_view)
    );

    smt_flag_ctl flg_i (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .suppress(suppress),
        .brk(dbg_brk), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .wflag(bus_wdata[B_FLAG]), .wie(bus_wdata[B_IE]),
        .flag(flag), .ie(ie), .irq(irq)
    );

    // read data mux for the addressed register
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT: begin
                bus_rdata[B_FLAG] = flag;
                bus_rdata[B_IE]   = ie;
            end
            A_CNT_H: bus_rdata = BUS_W'(cnt[CNT_W-1:BUS_W]);
            A_CNT_L: bus_rdata = lo_view;
            A_LIM_H: bus_rdata = BUS_W'(staged_hi);
            A_LIM_L: bus_rdata = limit[BUS_W-1:0];
            default: bus_rdata = '0;
        endcase
    end

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_addr != A_STAT || bus_rdata[B_FLAG]));
endmodule

// File: tb/split_mod_timer_tb.sv
`timescale 1ns/1ps
module split_mod_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       dbg_brk = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    split_mod_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_brk(dbg_brk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 check(req, int'(bus_rdata), exp);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk(3'd3, 8'hFF, "R2 limit hi");
        rd_chk(3'd4, 8'hFF, "R2 limit lo");
        rd_chk(3'd0, 8'h00, "R2 status");
        rd_chk(3'd1, 8'h00, "R2 count hi");
        rd_chk(3'd2, 8'h00, "R2 count lo");
        check("R2 irq", int'(irq), 0);
    endtask

    task automatic t_wrap();
        wr(3'd3, 8'h00); wr(3'd4, 8'h03); wr(3'd0, 8'h20);
        ticks(3);
        rd_chk(3'd2, 8'h03, "R1 count at limit");
        rd_chk(3'd0, 8'h00, "R1 no flag before wrap");
        ticks(1);
        rd_chk(3'd2, 8'h00, "R1 wrapped to zero");
        rd_chk(3'd0, 8'h80, "R1 flag set");
    endtask

    task automatic t_flag_clear();
        wr(3'd0, 8'h80);
        wr(3'd0, 8'h00);
        rd_chk(3'd0, 8'h80, "R9 write 1 / unarmed 0 keep flag");
        wr(3'd0, 8'h00);
        rd_chk(3'd0, 8'h00, "R9 armed clear");
        ticks(4);
        dbg_brk = 1'b1;
        rd_chk(3'd0, 8'h80, "R6 flag during break");
        dbg_brk = 1'b0;
        wr(3'd0, 8'h00);
        rd_chk(3'd0, 8'h80, "R6 break read does not arm");
        wr(3'd0, 8'h00);
    endtask

    task automatic t_irq();
        ticks(4);
        wr(3'd0, 8'h40);
        #2 check("R10 irq with flag and enable", int'(irq), 1);
        wr(3'd0, 8'h00);
        #2 check("R10 irq low with enable off", int'(irq), 0);
        rd_chk(3'd0, 8'h80, "R10 flag kept");
        wr(3'd0, 8'h00);
    endtask

    task automatic t_suppress();
        wr(3'd0, 8'h40);
        wr(3'd3, 8'h00);
        ticks(4);
        rd_chk(3'd2, 8'h00, "R3 still wraps");
        rd_chk(3'd0, 8'h40, "R3 flag suppressed");
        check("R3 irq suppressed", int'(irq), 0);
        wr(3'd4, 8'h03);
        ticks(4);
        rd_chk(3'd0, 8'hC0, "R3 flag after window");
        check("R3 irq after window", int'(irq), 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_mod_word();
        wr(3'd3, 8'h01);
        ticks(4);
        rd_chk(3'd2, 8'h00, "R11 old limit in force");
        rd_chk(3'd3, 8'h01, "R11 staged hi readback");
        rd_chk(3'd4, 8'h03, "R11 lo unchanged");
        wr(3'd4, 8'h02);
        ticks(5);
        rd_chk(3'd2, 8'h05, "R11 new limit 0x0102");
    endtask

    task automatic t_latch();
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd0, 8'h20);
        ticks(300);
        rd_chk(3'd1, 8'h01, "R4 count hi");
        ticks(5);
        rd_chk(3'd2, 8'h2C, "R4 captured lo");
        rd_chk(3'd2, 8'h31, "R4 live lo after release");
    endtask

    task automatic t_break();
        rd_chk(3'd1, 8'h01, "R5 count hi");
        dbg_brk = 1'b1;
        ticks(3);
        dbg_brk = 1'b0;
        ticks(2);
        rd_chk(3'd2, 8'h31, "R5 capture held past break");
        rd_chk(3'd2, 8'h33, "R6 no count in break");
    endtask

    task automatic t_ctl();
        wr(3'd1, 8'h55); wr(3'd2, 8'h66);
        rd_chk(3'd1, 8'h01, "R12 hi ignores write");
        rd_chk(3'd2, 8'h33, "R12 lo ignores write");
        wr(3'd0, 8'h20);
        rd_chk(3'd0, 8'h00, "R7 reset bit reads 0");
        rd_chk(3'd1, 8'h00, "R7 count hi cleared");
        rd_chk(3'd2, 8'h00, "R7 count lo cleared");
    endtask

    task automatic t_gating();
        repeat (10) @(negedge clk);
        rd_chk(3'd2, 8'h00, "R8 no tick no count");
        ticks(7);
        rd_chk(3'd2, 8'h07, "R8 counts on ticks");
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wrap();
        t_flag_clear();
        t_irq();
        t_suppress();
        t_mod_word();
        t_latch();
        t_break();
        t_ctl();
        t_gating();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule